// File: doc/BRIEF.md
# Interleaved Four-Module Memory Subsystem

This block spreads one 16-bit word address space over four independent memory modules and serves a single requester. Each request is split into a module index and a local offset, and is handed to the module it names. A module spends a fixed number of cycles on each access and takes nothing new until its result has been collected. Because of this, a run of requests aimed at different modules overlaps: the requester can start a new access every cycle while earlier modules are still busy.

A compile-time parameter chooses how addresses map onto modules. In high-order mode each module holds one contiguous quarter of the space. In low-order mode neighbouring addresses rotate through the modules.

A small queue of module indices records the order in which requests were accepted. Results are handed back strictly in that order. Both the request and the response sides are valid/ready streams. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` depends only on the presented address and the internal state, never on `req_valid`. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the pending response is held unchanged. The module that owns it stays busy, which in turn stalls later requests to that module.

Top module: `ilv_mem_sys`

## Requirements
- R1: In high-order mode (MODE = ILV_HIGH_ORDER), address bits [15:14] give the module index and bits [13:0] give the local offset. Addresses 0x0003 and 0x0004 therefore share module 0, while 0x4003 lies in module 1.
- R2: In low-order mode (MODE = ILV_LOW_ORDER), address bits [1:0] give the module index and bits [15:2] give the local offset. Addresses 0x0000 and 0x0004 therefore share module 0, while 0x0001 lies in module 1.
- R3: A module is busy from the edge that accepts a request for it until the edge on which that request's response transfers. `req_ready` is low whenever the presented address targets a busy module.
- R4: Requests to idle, different modules are accepted on consecutive clock edges, provided the queue has room.
- R5: When nothing else is outstanding, `rsp_valid` rises exactly LAT (default 4) edges after the accepting edge. It is low after LAT-1 edges.
- R6: Responses are returned in the order in which their requests were accepted, whatever the module mix.
- R7: At most TAG_DEPTH requests are outstanding at once. When TAG_DEPTH are outstanding, `req_ready` is low even for an idle module.
- R8: A read returns the word most recently written to the same address. A write produces one response with `rsp_write` = 1 and `rsp_rdata` = 0.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the next cycle keeps `rsp_valid` high with the same `rsp_rdata` and `rsp_write`.
- R10: After reset, `rsp_valid` is low and `req_ready` is high.
- R11: Each module stores 2^STORE_AW words (default 64). Only the low STORE_AW bits of the local offset select a word, so in high-order mode 0x0040 reads the word written at 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W | Read data, zero for a write |
| rsp_write | output | 1 | Response belongs to a write |

## Verification
On every cycle the assertions check four things. A held response stays stable under back-pressure. A just-accepted address cannot be accepted again on the next cycle. The outstanding count never passes TAG_DEPTH, and `req_ready` falls when it reaches it. No response appears while nothing is outstanding. Some behaviour only the bench scenarios can show. The address mapping in each mode is seen through which request pairs stall. The exact response latency, the data returned, offset aliasing and the issue order of responses that queue up behind a stalled requester are also checked by scenario.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    ILV_HIGH_ORDER = 1'b0,
    ILV_LOW_ORDER  = 1'b1
  } ilv_mode_e;

  localparam int unsigned ILV_MOD_BITS = 2;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned MOD_W  = 2,
  parameter ilv_mode_e   MODE   = ILV_HIGH_ORDER,
  localparam int unsigned OFF_W = ADDR_W - MOD_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MOD_W-1:0]  mod_idx,
  output logic [OFF_W-1:0]  offset
);
  generate
    if (MODE == ILV_HIGH_ORDER) begin : g_high
      // contiguous blocks: top bits pick the module
      assign mod_idx = addr[ADDR_W-1 -: MOD_W];
      assign offset  = addr[OFF_W-1:0];
    end else begin : g_low
      // rotating words: bottom bits pick the module
      assign mod_idx = addr[MOD_W-1:0];
      assign offset  = addr[ADDR_W-1:MOD_W];
    end
  endgenerate
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STORE_AW = 6,
  parameter int unsigned LAT      = 4,
  localparam int unsigned CNT_W   = $clog2(LAT + 1),
  localparam int unsigned WORDS   = 1 << STORE_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wr,
  input  logic [STORE_AW-1:0] word_sel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                release_i,
  output logic                busy,
  output logic                done,
  output logic                is_wr,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0]   store [WORDS];
  logic [CNT_W-1:0]    cnt;
  logic [STORE_AW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (start && wr) store[word_sel] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      is_wr <= 1'b0;
      cnt   <= '0;
      sel_q <= '0;
      rdata <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      is_wr <= wr;
      cnt   <= CNT_W'(LAT);
      sel_q <= word_sel;
    end else if (release_i) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        done  <= 1'b1;
        rdata <= is_wr ? '0 : store[sel_q];
      end
    end
  end
endmodule

// File: rtl/ilv_tag_fifo.sv
module ilv_tag_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] fill;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = slot[rp];
  assign full  = (fill == CNT_W'(DEPTH));
  assign empty = (fill == '0);

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/ilv_mem_sys.sv
module ilv_mem_sys
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MOD_W     = ILV_MOD_BITS,
  parameter int unsigned LAT       = 4,
  parameter int unsigned TAG_DEPTH = 4,
  parameter int unsigned STORE_AW  = 6,
  parameter ilv_mode_e   MODE      = ILV_HIGH_ORDER,
  localparam int unsigned NUM_MOD  = 1 << MOD_W,
  localparam int unsigned OFF_W    = ADDR_W - MOD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_write
);
  logic [MOD_W-1:0]  req_mod;
  logic [OFF_W-1:0]  req_off;
  logic [NUM_MOD-1:0] bank_busy, bank_done, bank_iswr, bank_start, bank_rel;
  logic [DATA_W-1:0] bank_rdata [NUM_MOD];
  logic [MOD_W-1:0]  head_mod;
  logic              q_full, q_empty;
  logic              accept, take;

  ilv_addr_split #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .MODE(MODE)) u_split (
    .addr    (req_addr),
    .mod_idx (req_mod),
    .offset  (req_off)
  );

  generate
    if (OFF_W > STORE_AW) begin : g_alias
      logic unused_off_hi;
      assign unused_off_hi = ^req_off[OFF_W-1:STORE_AW];
    end
  endgenerate

  assign req_ready = !bank_busy[req_mod] && !q_full;
  assign accept    = req_valid && req_ready;

  assign rsp_valid = !q_empty && bank_done[head_mod];
  assign rsp_rdata = bank_rdata[head_mod];
  assign rsp_write = bank_iswr[head_mod];
  assign take      = rsp_valid && rsp_ready;

  ilv_tag_fifo #(.DEPTH(TAG_DEPTH), .W(MOD_W)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (req_mod),
    .pop   (take),
    .head  (head_mod),
    .full  (q_full),
    .empty (q_empty)
  );

  generate
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_bank
      assign bank_start[i] = accept && (req_mod == MOD_W'(i));
      assign bank_rel[i]   = take && (head_mod == MOD_W'(i));

      ilv_bank #(.DATA_W(DATA_W), .STORE_AW(STORE_AW), .LAT(LAT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bank_start[i]),
        .wr        (req_write),
        .word_sel  (req_off[STORE_AW-1:0]),
        .wdata     (req_wdata),
        .release_i (bank_rel[i]),
        .busy      (bank_busy[i]),
        .done      (bank_done[i]),
        .is_wr     (bank_iswr[i]),
        .rdata     (bank_rdata[i])
      );
    end
  endgenerate
endmodule

// File: rtl/ilv_mem_sys_chk.sv
module ilv_mem_sys_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_DEPTH = 4,
  localparam int unsigned OC_W     = $clog2(TAG_DEPTH + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_write
);
  logic [OC_W-1:0] outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else case ({req_valid && req_ready, rsp_valid && rsp_ready})
      2'b10:   outstanding <= outstanding + 1'b1;
      2'b01:   outstanding <= outstanding - 1'b1;
      default: outstanding <= outstanding;
    endcase
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_write));

  p_same_addr_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !(req_valid && req_ready && $stable(req_addr)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= OC_W'(TAG_DEPTH));

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding == OC_W'(TAG_DEPTH) |-> !req_ready);

  p_no_orphan_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding == '0 |-> !rsp_valid);

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);
endmodule

bind ilv_mem_sys ilv_mem_sys_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_DEPTH(TAG_DEPTH)
) u_chk (.*);

// File: tb/tb_ilv_mem_sys.sv
`timescale 1ns/1ps
module tb_ilv_mem_sys;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // high-order instance, queue depth 4
  logic h_req_valid = 0, h_req_write = 0, h_rsp_ready = 1;
  logic [15:0] h_req_addr = '0;
  logic [31:0] h_req_wdata = '0;
  logic h_req_ready, h_rsp_valid, h_rsp_write;
  logic [31:0] h_rsp_rdata;

  // low-order instance, queue depth 2
  logic l_req_valid = 0, l_req_write = 0, l_rsp_ready = 1;
  logic [15:0] l_req_addr = '0;
  logic [31:0] l_req_wdata = '0;
  logic l_req_ready, l_rsp_valid, l_rsp_write;
  logic [31:0] l_rsp_rdata;

  ilv_mem_sys #(.MODE(ilv_pkg::ILV_HIGH_ORDER), .TAG_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(h_req_valid), .req_ready(h_req_ready), .req_write(h_req_write),
    .req_addr(h_req_addr), .req_wdata(h_req_wdata),
    .rsp_valid(h_rsp_valid), .rsp_ready(h_rsp_ready),
    .rsp_rdata(h_rsp_rdata), .rsp_write(h_rsp_write)
  );

  ilv_mem_sys #(.MODE(ilv_pkg::ILV_LOW_ORDER), .TAG_DEPTH(2)) dut_lo (
    .clk(clk), .rst_n(rst_n),
    .req_valid(l_req_valid), .req_ready(l_req_ready), .req_write(l_req_write),
    .req_addr(l_req_addr), .req_wdata(l_req_wdata),
    .rsp_valid(l_rsp_valid), .rsp_ready(l_rsp_ready),
    .rsp_rdata(l_rsp_rdata), .rsp_write(l_rsp_write)
  );

  logic [31:0] h_log_d [64];
  logic        h_log_w [64];
  int h_n = 0;
  logic [31:0] l_log_d [64];
  int l_n = 0;

  always @(posedge clk) begin
    if (rst_n && h_rsp_valid && h_rsp_ready) begin
      h_log_d[h_n] <= h_rsp_rdata;
      h_log_w[h_n] <= h_rsp_write;
      h_n <= h_n + 1;
    end
    if (rst_n && l_rsp_valid && l_rsp_ready) begin
      l_log_d[l_n] <= l_rsp_rdata;
      l_n <= l_n + 1;
    end
  end

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 16'h0003, 32'hA1A1_0003, 32'h0},
    '{1'b1, 16'h4003, 32'hB2B2_4003, 32'h0},
    '{1'b1, 16'h8003, 32'hC3C3_8003, 32'h0},
    '{1'b1, 16'hC003, 32'hD4D4_C003, 32'h0},
    '{1'b1, 16'h0000, 32'hE5E5_0000, 32'h0},
    '{1'b0, 16'h0003, 32'h0, 32'hA1A1_0003},
    '{1'b0, 16'h4003, 32'h0, 32'hB2B2_4003},
    '{1'b0, 16'h8003, 32'h0, 32'hC3C3_8003},
    '{1'b0, 16'hC003, 32'h0, 32'hD4D4_C003},
    '{1'b0, 16'h0040, 32'h0, 32'hE5E5_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic h_issue(input logic wr, input logic [15:0] a, input logic [31:0] d);
    h_req_write = wr; h_req_addr = a; h_req_wdata = d; h_req_valid = 1'b1;
    @(negedge clk);
    while (!h_req_ready) @(negedge clk);
    @(posedge clk); #1;
    h_req_valid = 1'b0;
  endtask

  task automatic l_issue(input logic wr, input logic [15:0] a, input logic [31:0] d);
    l_req_write = wr; l_req_addr = a; l_req_wdata = d; l_req_valid = 1'b1;
    @(negedge clk);
    while (!l_req_ready) @(negedge clk);
    @(posedge clk); #1;
    l_req_valid = 1'b0;
  endtask

  task automatic h_wait(input int n);
    while (h_n < n) @(negedge clk);
  endtask

  task automatic l_wait(input int n);
    while (l_n < n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    chk(h_req_ready == 1'b1, "R10 hi ready", 32'(h_req_ready), 32'd1);
    chk(h_rsp_valid == 1'b0, "R10 hi rsp_valid", 32'(h_rsp_valid), 32'd0);
    chk(l_req_ready == 1'b1, "R10 lo ready", 32'(l_req_ready), 32'd1);
    chk(l_rsp_valid == 1'b0, "R10 lo rsp_valid", 32'(l_rsp_valid), 32'd0);

    // table walk: R8 data and write acks, R11 aliasing
    for (int i = 0; i < 10; i++) begin
      base = h_n;
      @(posedge clk); #1;
      h_issue(VECS[i].wr, VECS[i].addr, VECS[i].data);
      h_wait(base + 1);
      chk(h_log_d[base] == VECS[i].exp, (i == 9) ? "R11 alias read" : "R8 data",
          h_log_d[base], VECS[i].exp);
      chk(h_log_w[base] == VECS[i].wr, "R8 write flag", 32'(h_log_w[base]), 32'(VECS[i].wr));
    end

    // overlap, decode and latency on the high-order instance
    repeat (2) @(negedge clk);
    base = h_n;
    @(posedge clk); #1;
    h_req_write = 0; h_req_addr = 16'h0003; h_req_valid = 1;
    @(negedge clk);
    chk(h_req_ready == 1'b1, "R4 first accept", 32'(h_req_ready), 32'd1);
    @(posedge clk); #1;                 // edge e0 accepts module 0
    h_req_addr = 16'h4003;
    @(negedge clk);
    chk(h_req_ready == 1'b1, "R4 R1 other module back-to-back", 32'(h_req_ready), 32'd1);
    @(posedge clk); #1;                 // e1 accepts module 1
    h_req_addr = 16'h0004;
    @(negedge clk);
    chk(h_req_ready == 1'b0, "R1 R3 same module stall", 32'(h_req_ready), 32'd0);
    @(posedge clk); #1;                 // e2
    h_req_valid = 0;
    @(negedge clk);
    @(posedge clk);                     // e3
    @(negedge clk);
    chk(h_rsp_valid == 1'b0, "R5 not before LAT", 32'(h_rsp_valid), 32'd0);
    @(posedge clk);                     // e4
    @(negedge clk);
    chk(h_rsp_valid == 1'b1, "R5 valid at LAT", 32'(h_rsp_valid), 32'd1);
    chk(h_rsp_rdata == 32'hA1A1_0003, "R5 data", h_rsp_rdata, 32'hA1A1_0003);
    h_wait(base + 2);
    chk(h_log_d[base + 1] == 32'hB2B2_4003, "R6 second in order", h_log_d[base + 1], 32'hB2B2_4003);

    // back-pressure: four reads queue up, issue order D,C,B,A
    repeat (2) @(negedge clk);
    base = h_n;
    h_rsp_ready = 0;
    @(posedge clk); #1;
    h_issue(0, 16'hC003, 0);
    h_issue(0, 16'h8003, 0);
    h_issue(0, 16'h4003, 0);
    h_issue(0, 16'h0003, 0);
    h_req_addr = 16'h0000; h_req_write = 0; h_req_valid = 1;
    @(negedge clk);
    chk(h_req_ready == 1'b0, "R7 R3 hi four outstanding", 32'(h_req_ready), 32'd0);
    @(posedge clk); #1;
    h_req_valid = 0;
    repeat (8) @(negedge clk);
    chk(h_rsp_valid == 1'b1, "R9 held valid", 32'(h_rsp_valid), 32'd1);
    chk(h_rsp_rdata == 32'hD4D4_C003, "R6 head is first issued", h_rsp_rdata, 32'hD4D4_C003);
    held = h_rsp_rdata;
    repeat (3) @(negedge clk);
    chk(h_rsp_rdata == held && h_rsp_valid, "R9 stable under stall", h_rsp_rdata, held);
    @(posedge clk); #1;
    h_rsp_ready = 1;
    h_wait(base + 4);
    chk(h_log_d[base]     == 32'hD4D4_C003, "R6 order 0", h_log_d[base],     32'hD4D4_C003);
    chk(h_log_d[base + 1] == 32'hC3C3_8003, "R6 order 1", h_log_d[base + 1], 32'hC3C3_8003);
    chk(h_log_d[base + 2] == 32'hB2B2_4003, "R6 order 2", h_log_d[base + 2], 32'hB2B2_4003);
    chk(h_log_d[base + 3] == 32'hA1A1_0003, "R6 order 3", h_log_d[base + 3], 32'hA1A1_0003);

    // low-order instance: data, decode and queue depth
    base = l_n;
    @(posedge clk); #1;
    l_issue(1, 16'h0001, 32'h1234_0001);
    l_wait(base + 1);
    @(posedge clk); #1;
    l_issue(0, 16'h0001, 0);
    l_wait(base + 2);
    chk(l_log_d[base + 1] == 32'h1234_0001, "R8 R2 lo readback", l_log_d[base + 1], 32'h1234_0001);

    repeat (2) @(negedge clk);
    base = l_n;
    @(posedge clk); #1;
    l_req_write = 0; l_req_addr = 16'h0000; l_req_valid = 1;
    @(negedge clk);
    chk(l_req_ready == 1'b1, "R2 lo first accept", 32'(l_req_ready), 32'd1);
    @(posedge clk); #1;                 // accepts module 0
    l_req_addr = 16'h0004;
    @(negedge clk);
    chk(l_req_ready == 1'b0, "R2 lo 0x0004 shares module 0", 32'(l_req_ready), 32'd0);
    @(posedge clk); #1;
    l_req_addr = 16'h0001;
    @(negedge clk);
    chk(l_req_ready == 1'b1, "R2 R4 lo 0x0001 other module", 32'(l_req_ready), 32'd1);
    @(posedge clk); #1;                 // accepts module 1, two outstanding
    l_req_addr = 16'h0002;
    @(negedge clk);
    chk(l_req_ready == 1'b0, "R7 lo depth two full", 32'(l_req_ready), 32'd0);
    @(posedge clk); #1;
    l_req_valid = 0;
    l_wait(base + 2);
    chk(l_log_d[base + 1] == 32'h1234_0001, "R6 lo order", l_log_d[base + 1], 32'h1234_0001);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule